// File: doc/BRIEF.md
# Two-Speed Start-Up Clock Source Controller

This block decides which clock source drives the core after a reset and after every wake from sleep. When the start-up bridge is enabled and the primary oscillator runs in one of the crystal modes, the core first runs from the internal oscillator. Meanwhile the block counts rising edges of the primary oscillator. In the PLL crystal mode it then also waits for the PLL to lock. Once that count is complete, the block hands the core to the primary source and raises a primary-running flag. If the bridge is disabled or the primary mode is not crystal-based, the primary source is selected at once.

Software may still change its requested source, or put the device back to sleep, before the start-up count finishes. In both cases the block follows the new request and never touches the primary source. The internal source is described by a 3-bit frequency select. A value of zero means the base frequency and any other value means a postscaled rate. After a reset the select register outside the block is cleared, so the base clock is used until software writes a faster value. A value written before sleep is used again on wake.

Top module: `tsu_clk_ctrl`

## Requirements
- R1: While `rst_n` is low, `clk_sel_o` is 2'b00, `pri_run_o` is 0 and `div_sel_o` is 0.
- R2: In the first cycle after reset, and on a wake while asleep with `use_int_i` low, the block enters warm-up if `bridge_en_i` is 1 and `pri_mode_i` is a crystal mode (codes 0 LP, 1 XT, 2 HS, 3 HS with PLL). In warm-up the internal clock is selected and `pri_run_o` is 0.
- R3: Under the same events, if `bridge_en_i` is 0 or `pri_mode_i` is 4..7, the next cycle shows `clk_sel_o` = 2'b10 and `pri_run_o` = 1.
- R4: In warm-up the switch to the primary source (`clk_sel_o` = 2'b10, `pri_run_o` = 1) happens within 4 clock cycles after the OST_COUNT-th (default 1024) synchronised rising edge of `pri_osc_i`, and never earlier.
- R5: In mode 3 the switch also waits PLL_WAIT further clock cycles, counted only after the edge count completes.
- R6: While the internal source is selected, `clk_sel_o` is 2'b00 when `freq_sel_i` is 0 and 2'b01 otherwise. `div_sel_o` shows `freq_sel_i` one cycle after it is sampled.
- R7: A `sleep_req_i` pulse in any awake state gives `clk_sel_o` = 2'b11 and `pri_run_o` = 0 in the next cycle, and clears the edge and PLL counts. A later warm-up therefore needs a full count again.
- R8: A wake from sleep uses the current `freq_sel_i` for the internal clock. If `use_int_i` is 1 at wake, the block goes directly to internal run.
- R9: Raising `use_int_i` during warm-up moves the block to internal run next cycle. The primary source is then never selected, whatever edges arrive.
- R10: Lowering `use_int_i` in internal run ignores `bridge_en_i`. In crystal modes the internal clock is kept through a full warm-up before the switch; in modes 4..7 the primary source is selected next cycle.
- R11: `wake_i` has no effect while awake, and `sleep_req_i` has no effect while asleep.
- R12: Raising `use_int_i` while the primary source is selected gives the internal clock and `pri_run_o` = 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running control clock |
| rst_n | input | 1 | Active-low reset (any reset event) |
| wake_i | input | 1 | Wake event pulse |
| sleep_req_i | input | 1 | Sleep request pulse |
| use_int_i | input | 1 | Software source request: 1 internal block, 0 primary |
| bridge_en_i | input | 1 | Start-up bridge enable configuration bit |
| pri_mode_i | input | 3 | Primary oscillator mode code |
| pri_osc_i | input | 1 | Primary oscillator, asynchronous to `clk` |
| freq_sel_i | input | 3 | Internal frequency select |
| clk_sel_o | output | 2 | 00 internal base, 01 internal postscaled, 10 primary, 11 stopped |
| pri_run_o | output | 1 | Primary source is clocking the core |
| div_sel_o | output | 3 | Postscaler select for the internal source |

## Verification
Every control input is sampled on one rising edge, and every output shows its new value at that same edge. The bench therefore drives inputs at a falling edge and compares the outputs at the next falling edge, one cycle later. A primary oscillator edge passes two synchroniser flops, an edge detector, the counter and the state register before it can reach the outputs. For that reason the switch is checked at two points: several cycles after the last edge of a count that is one short, where it must not yet have happened, and several cycles after the final edge, where it must have happened. The PLL wait is checked in the same way, 20 cycles before and 20 cycles after its nominal end.

// File: rtl/tsu_pkg.sv
package tsu_pkg;
    typedef enum logic [2:0] {
        ST_BOOT  = 3'd0,
        ST_WARM  = 3'd1,
        ST_PRI   = 3'd2,
        ST_INT   = 3'd3,
        ST_SLEEP = 3'd4
    } tsu_state_e;

    localparam logic [1:0] CSEL_INT_BASE = 2'b00;
    localparam logic [1:0] CSEL_INT_POST = 2'b01;
    localparam logic [1:0] CSEL_PRIMARY  = 2'b10;
    localparam logic [1:0] CSEL_STOPPED  = 2'b11;

    localparam logic [2:0] MODE_HS_PLL = 3'd3;

    function automatic logic is_crystal(input logic [2:0] mode);
        return (mode[2] == 1'b0);
    endfunction
endpackage

// File: rtl/tsu_edge_sync.sv
module tsu_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d.s1 = async_i;
        r_d.s2 = r_q.s1;
        r_d.s3 = r_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rise_o = r_q.s2 & ~r_q.s3;

    // R4
    one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/tsu_startup_timer.sv
module tsu_startup_timer #(
    parameter int OST_COUNT = 1024,
    parameter int PLL_WAIT  = 16000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic edge_i,
    input  logic pll_mode_i,
    output logic done_o
);
    localparam int OW = $clog2(OST_COUNT + 2);
    localparam int PW = $clog2(PLL_WAIT + 2);

    typedef struct packed {
        logic [OW-1:0] ost;
        logic [PW-1:0] pll;
    } tmr_t;

    tmr_t r_d, r_q;
    logic ost_full;
    logic pll_full;

    assign ost_full = (r_q.ost == OW'(OST_COUNT));

    generate
        if (PLL_WAIT > 0) begin : g_pll
            assign pll_full = (r_q.pll == PW'(PLL_WAIT));
        end else begin : g_no_pll
            assign pll_full = 1'b1;
        end
    endgenerate

    always_comb begin
        r_d = r_q;
        if (clr_i) begin
            r_d = '0;
        end else begin
            if (edge_i && !ost_full)
                r_d.ost = r_q.ost + OW'(1);
            if (ost_full && pll_mode_i && !pll_full)
                r_d.pll = r_q.pll + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign done_o = ost_full && (!pll_mode_i || pll_full);

    // R4
    ost_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ost <= OW'(OST_COUNT));
    // R5
    pll_after_ost_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.pll != '0) |-> ost_full);
endmodule

// File: rtl/tsu_src_fsm.sv
module tsu_src_fsm
    import tsu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wake_i,
    input  logic       sleep_req_i,
    input  logic       use_int_i,
    input  logic       bridge_en_i,
    input  logic [2:0] pri_mode_i,
    input  logic [2:0] freq_sel_i,
    input  logic       tmr_done_i,
    output logic       tmr_clr_o,
    output logic       pll_mode_o,
    output logic [1:0] clk_sel_o,
    output logic       pri_run_o,
    output logic [2:0] div_sel_o
);
    typedef struct packed {
        tsu_state_e st;
        logic [1:0] csel;
        logic       prun;
        logic [2:0] div;
    } fsm_t;

    fsm_t r_d, r_q;
    tsu_state_e wake_target;

    always_comb begin
        if (use_int_i)
            wake_target = ST_INT;
        else if (bridge_en_i && is_crystal(pri_mode_i))
            wake_target = ST_WARM;
        else
            wake_target = ST_PRI;
    end

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_BOOT:  r_d.st = wake_target;
            ST_SLEEP: if (wake_i) r_d.st = wake_target;
            ST_WARM: begin
                if (sleep_req_i)     r_d.st = ST_SLEEP;
                else if (use_int_i)  r_d.st = ST_INT;
                else if (tmr_done_i) r_d.st = ST_PRI;
            end
            ST_PRI: begin
                if (sleep_req_i)    r_d.st = ST_SLEEP;
                else if (use_int_i) r_d.st = ST_INT;
            end
            ST_INT: begin
                if (sleep_req_i)
                    r_d.st = ST_SLEEP;
                else if (!use_int_i)
                    r_d.st = is_crystal(pri_mode_i) ? ST_WARM : ST_PRI;
            end
            default: r_d.st = ST_BOOT;
        endcase

        r_d.div = freq_sel_i;
        case (r_d.st)
            ST_PRI: begin
                r_d.csel = CSEL_PRIMARY;
                r_d.prun = 1'b1;
            end
            ST_SLEEP: begin
                r_d.csel = CSEL_STOPPED;
                r_d.prun = 1'b0;
            end
            default: begin
                r_d.csel = (freq_sel_i == 3'd0) ? CSEL_INT_BASE : CSEL_INT_POST;
                r_d.prun = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_BOOT;
            r_q.csel <= CSEL_INT_BASE;
            r_q.prun <= 1'b0;
            r_q.div  <= 3'd0;
        end else begin
            r_q <= r_d;
        end
    end

    assign tmr_clr_o  = (r_q.st != ST_WARM);
    assign pll_mode_o = (pri_mode_i == MODE_HS_PLL);
    assign clk_sel_o  = r_q.csel;
    assign pri_run_o  = r_q.prun;
    assign div_sel_o  = r_q.div;

    // R7
    sleep_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_SLEEP && r_q.st != ST_BOOT && sleep_req_i)
            |=> (clk_sel_o == CSEL_STOPPED && !pri_run_o));
    // R4
    no_early_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WARM && !sleep_req_i && !use_int_i && !tmr_done_i)
            |=> !pri_run_o);
    // R9
    int_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WARM && use_int_i && !sleep_req_i)
            |=> (clk_sel_o != CSEL_PRIMARY));
    // R11
    sleep_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SLEEP && !wake_i) |=> (clk_sel_o == CSEL_STOPPED));
endmodule

// File: rtl/tsu_clk_ctrl.sv
module tsu_clk_ctrl #(
    parameter int OST_COUNT = 1024,
    parameter int PLL_WAIT  = 16000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wake_i,
    input  logic       sleep_req_i,
    input  logic       use_int_i,
    input  logic       bridge_en_i,
    input  logic [2:0] pri_mode_i,
    input  logic       pri_osc_i,
    input  logic [2:0] freq_sel_i,
    output logic [1:0] clk_sel_o,
    output logic       pri_run_o,
    output logic [2:0] div_sel_o
);
    logic osc_rise;
    logic tmr_clr;
    logic tmr_done;
    logic pll_mode;

    tsu_edge_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pri_osc_i),
        .rise_o  (osc_rise)
    );

    tsu_startup_timer #(
        .OST_COUNT (OST_COUNT),
        .PLL_WAIT  (PLL_WAIT)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (tmr_clr),
        .edge_i     (osc_rise),
        .pll_mode_i (pll_mode),
        .done_o     (tmr_done)
    );

    tsu_src_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wake_i      (wake_i),
        .sleep_req_i (sleep_req_i),
        .use_int_i   (use_int_i),
        .bridge_en_i (bridge_en_i),
        .pri_mode_i  (pri_mode_i),
        .freq_sel_i  (freq_sel_i),
        .tmr_done_i  (tmr_done),
        .tmr_clr_o   (tmr_clr),
        .pll_mode_o  (pll_mode),
        .clk_sel_o   (clk_sel_o),
        .pri_run_o   (pri_run_o),
        .div_sel_o   (div_sel_o)
    );
endmodule

// File: tb/tsu_clk_ctrl_test.sv
`timescale 1ns/1ps
module tsu_clk_ctrl_test;
    localparam int OST = 1024;
    localparam int PLLW = 3000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wake = 1'b0, slp = 1'b0, use_int = 1'b0, en = 1'b1, osc = 1'b0;
    logic [2:0] mode = 3'd2, freq = 3'd0;
    logic [1:0] csel;
    logic prun;
    logic [2:0] div;
    int n_tests = 0;
    int n_fail = 0;
    bit done_flag = 1'b0;

    always #10 clk = ~clk;

    tsu_clk_ctrl #(.OST_COUNT(OST), .PLL_WAIT(PLLW)) uut (
        .clk(clk), .rst_n(rst_n), .wake_i(wake), .sleep_req_i(slp),
        .use_int_i(use_int), .bridge_en_i(en), .pri_mode_i(mode),
        .pri_osc_i(osc), .freq_sel_i(freq), .clk_sel_o(csel),
        .pri_run_o(prun), .div_sel_o(div)
    );

    // Reference model states: 0 boot, 1 warm-up, 2 primary, 3 internal run, 4 sleep
    function automatic int pick(bit ui, bit be, logic [2:0] md);
        if (ui) return 3;
        if (be && md < 3'd4) return 1;
        return 2;
    endfunction

    function automatic int model_next(int s, bit sr, bit wk, bit ui, bit be, logic [2:0] md);
        case (s)
            0: return pick(ui, be, md);
            4: return wk ? pick(ui, be, md) : 4;
            1, 2: begin
                if (sr) return 4;
                if (ui) return 3;
                return s;
            end
            default: begin
                if (sr) return 4;
                if (!ui) return (md < 3'd4) ? 1 : 2;
                return 3;
            end
        endcase
    endfunction

    function automatic logic [1:0] model_sel(int s, logic [2:0] f);
        if (s == 2) return 2'b10;
        if (s == 4) return 2'b11;
        return (f == 3'd0) ? 2'b00 : 2'b01;
    endfunction

    task automatic check(input string req, input logic [1:0] es, input logic eo, input logic [2:0] ed);
        n_tests++;
        if (csel !== es || prun !== eo || div !== ed) begin
            n_fail++;
            $display("FAIL %s: clk_sel=%b pri_run=%b div=%0d expected clk_sel=%b pri_run=%b div=%0d",
                     req, csel, prun, div, es, eo, ed);
        end
    endtask

    task automatic step();
        @(negedge clk);
        wake = 1'b0;
        slp  = 1'b0;
    endtask

    task automatic pulse_sleep();
        slp = 1'b1;
        step();
    endtask

    task automatic pulse_wake();
        wake = 1'b1;
        step();
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) begin
            osc = 1'b1;
            repeat (2) @(negedge clk);
            osc = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
        finish_run();
    end

    initial begin
        int s;
        void'($urandom(32'h1234_5678));
        // R1 reset values
        idle(3);
        check("R1", 2'b00, 1'b0, 3'd0);

        // R2 bridge after reset, HS mode
        rst_n = 1'b1;
        step();
        check("R2", 2'b00, 1'b0, 3'd0);
        // R6 postscaled select
        freq = 3'd5;
        step();
        check("R6", 2'b01, 1'b0, 3'd5);
        // R4 one edge short, then the last edge
        edges(OST - 1);
        idle(6);
        check("R4", 2'b01, 1'b0, 3'd5);
        edges(1);
        idle(2);
        check("R4", 2'b10, 1'b1, 3'd5);

        // R7 sleep
        pulse_sleep();
        check("R7", 2'b11, 1'b0, 3'd5);
        // R8 wake with PLL crystal mode; freq from before sleep
        mode = 3'd3;
        pulse_wake();
        check("R8", 2'b01, 1'b0, 3'd5);
        // R5 PLL wait after the edge count
        edges(OST);
        idle(6);
        check("R5", 2'b01, 1'b0, 3'd5);
        idle(PLLW - 26);
        check("R5", 2'b01, 1'b0, 3'd5);
        idle(40);
        check("R5", 2'b10, 1'b1, 3'd5);

        // R7 counter cleared by sleep
        mode = 3'd2;
        freq = 3'd0;
        pulse_sleep();
        pulse_wake();
        edges(600);
        pulse_sleep();
        pulse_wake();
        edges(600);
        idle(6);
        check("R7", 2'b00, 1'b0, 3'd0);
        edges(OST - 600);
        idle(2);
        check("R7", 2'b10, 1'b1, 3'd0);

        // R11 wake ignored while awake, sleep ignored while asleep
        pulse_wake();
        check("R11", 2'b10, 1'b1, 3'd0);
        pulse_sleep();
        pulse_sleep();
        check("R11", 2'b11, 1'b0, 3'd0);

        // R3 bridge disabled / non-crystal mode
        en = 1'b0;
        pulse_wake();
        check("R3", 2'b10, 1'b1, 3'd0);
        pulse_sleep();
        en = 1'b1;
        mode = 3'd5;
        pulse_wake();
        check("R3", 2'b10, 1'b1, 3'd0);

        // R9 leave warm-up for internal run, primary never used
        pulse_sleep();
        mode = 3'd1;
        freq = 3'd2;
        pulse_wake();
        check("R2", 2'b01, 1'b0, 3'd2);
        use_int = 1'b1;
        step();
        check("R9", 2'b01, 1'b0, 3'd2);
        edges(OST + 80);
        idle(6);
        check("R9", 2'b01, 1'b0, 3'd2);

        // R8 wake directly into internal run
        pulse_sleep();
        pulse_wake();
        check("R8", 2'b01, 1'b0, 3'd2);
        // R10 enable ignored, crystal mode warms up first
        en = 1'b0;
        use_int = 1'b0;
        step();
        check("R10", 2'b01, 1'b0, 3'd2);
        edges(OST);
        idle(2);
        check("R10", 2'b10, 1'b1, 3'd2);
        // R12 primary back to internal
        use_int = 1'b1;
        step();
        check("R12", 2'b01, 1'b0, 3'd2);
        // R10 non-crystal mode switches at once
        mode = 3'd6;
        use_int = 1'b0;
        step();
        check("R10", 2'b10, 1'b1, 3'd2);

        // Constrained random sequence against the reference model
        rst_n = 1'b0;
        use_int = 1'b0;
        freq = 3'd0;
        en = 1'b1;
        mode = 3'd0;
        idle(2);
        rst_n = 1'b1;
        s = 0;
        for (int k = 0; k < 400; k++) begin
            int r;
            r = int'($urandom % 10);
            case (r)
                0: slp = 1'b1;
                1: wake = 1'b1;
                2: use_int = ~use_int;
                3: freq = 3'($urandom);
                4: mode = 3'($urandom);
                5: en = ~en;
                default: ;
            endcase
            s = model_next(s, slp, wake, use_int, en, mode);
            step();
            check("R6/R7/R8/R11", model_sel(s, freq), (s == 2), freq);
        end
        finish_run();
    end
endmodule